// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one accepted read or write request into the series of column addresses that a synchronous DRAM burst visits. A start strobe captures a starting column, a three-bit burst length code and a burst-order select. Starting on the next clock, the block presents one column per cycle with a valid flag. A last flag marks the closing beat of a fixed-length burst. Every address stays inside an aligned block whose size is the burst length. Only the low log2(length) bits move, and they wrap inside the block without carrying into the bits above.

Beats can follow one of two orders. Sequential order counts upward modulo the length. Interleaved order XORs the start offset with the beat index. A page-length mode, which is legal only with sequential order, walks the whole column range and wraps at its end. It runs until a terminate strobe arrives, so the controller can make bursts of any length. Terminate also ends a fixed-length burst early. While a burst is running the block reports busy and ignores new start strobes. A start carrying an unsupported code produces a one-cycle error pulse and no burst. The column width is a parameter; the default of 9 bits suits a 16-bit-wide device.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, valid_o, last_o, busy_o and err_o are all low.
- R2: Length codes map 3'b000 to 1 beat, 3'b001 to 2, 3'b010 to 4 and 3'b011 to 8. A start accepted at a clock edge gives valid_o high on exactly that many following cycles, beginning the cycle after the edge.
- R3: In a fixed-length burst of length BL, the column bits above the low log2(BL) bits equal those of the starting column on every beat.
- R4: With burst_ilv_i low (sequential), the low log2(BL) bits on beat n (n = 0..BL-1) are (start + n) mod BL.
- R5: With burst_ilv_i high (interleaved), the low log2(BL) bits on beat n are start XOR n.
- R6: last_o is high on the final beat of a fixed-length burst and on no other cycle, and valid_o is low on the cycle after that beat.
- R7: Code 3'b111 with sequential order selects page length. On beat n the column is (start + n) mod 2^COL_W, the burst continues past 2^COL_W beats, and last_o stays low.
- R8: When term_i is high at an edge while valid_o is high, the beat on show is the burst's final one and valid_o is low on the next cycle. When no burst is running, term_i has no effect.
- R9: busy_o is high exactly while valid_o is high. A start strobe received while busy_o is high is ignored, and the running burst continues unchanged.
- R10: A start while idle with code 3'b100, 3'b101 or 3'b110, or with page length and interleaved order, raises err_o for exactly one cycle and starts no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; captures column, code and order |
| col_i | input | COL_W | Starting column |
| bl_code_i | input | 3 | Burst length code |
| burst_ilv_i | input | 1 | 0 = sequential order, 1 = interleaved order |
| term_i | input | 1 | Terminate request for the running burst |
| col_o | output | COL_W | Column address for the current beat |
| valid_o | output | 1 | col_o holds a beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| busy_o | output | 1 | A burst is running |
| err_o | output | 1 | One-cycle pulse: start with an unsupported code was rejected |

## Verification
The bench starts bursts at offsets that force a wrap inside the block, such as offset 6 of an 8-beat block or offset 3 of a 4-beat block. A design that lets the count carry would change the block bits. A design that mixes up the two orders would show the wrong beat sequence. A page burst starts near the top of the column range and runs past a full lap, which exposes any early stop and any missing wrap at the page end. Further cases cover an early terminate, a terminate while idle, a start during a burst, and each rejected code including page length with interleaved order. A design that got these wrong would show too many or too few beats, or would restart on a second start, or would begin a burst where it should only raise the error flag.

// File: rtl/bcag_pkg.sv
package bcag_pkg;

    typedef enum logic [2:0] {
        BLC_ONE   = 3'b000,
        BLC_TWO   = 3'b001,
        BLC_FOUR  = 3'b010,
        BLC_EIGHT = 3'b011,
        BLC_PAGE  = 3'b111
    } blen_code_e;

endpackage

// File: rtl/bcag_decode.sv
module bcag_decode
    import bcag_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [2:0]       code_i,
    input  logic             ilv_i,
    output logic             legal_o,
    output logic             page_o,
    output logic [COL_W-1:0] mask_o
);

    logic known;

    always_comb begin
        known  = 1'b1;
        page_o = 1'b0;
        mask_o = '0;
        case (code_i)
            BLC_ONE:   mask_o = COL_W'(0);
            BLC_TWO:   mask_o = COL_W'(1);
            BLC_FOUR:  mask_o = COL_W'(3);
            BLC_EIGHT: mask_o = COL_W'(7);
            BLC_PAGE: begin
                mask_o = '1;
                page_o = 1'b1;
            end
            default:   known = 1'b0;
        endcase
        // page length only pairs with sequential order
        legal_o = known && !(page_o && ilv_i);
    end

endmodule

// File: rtl/bcag_colgen.sv
module bcag_colgen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] seq_off;
    logic [COL_W-1:0] ilv_off;

    assign seq_off = base_i + beat_i;
    assign ilv_off = base_i ^ beat_i;

    // per bit: masked bits move, the rest keep the block position
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col_o[i] = mask_i[i] ? (ilv_i ? ilv_off[i] : seq_off[i])
                                    : base_i[i];
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcag_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [2:0]       bl_code_i,
    input  logic             burst_ilv_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             busy_o,
    output logic             err_o
);

    typedef struct packed {
        logic             active;
        logic             last;
        logic             err;
        logic             ilv;
        logic             page;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] col;
    } state_t;

    state_t st_d, st_q;

    logic             dec_legal;
    logic             dec_page;
    logic [COL_W-1:0] dec_mask;
    logic [COL_W-1:0] beat_nx;
    logic [COL_W-1:0] col_nx;
    logic             at_end;

    bcag_decode #(.COL_W(COL_W)) u_decode (
        .code_i  (bl_code_i),
        .ilv_i   (burst_ilv_i),
        .legal_o (dec_legal),
        .page_o  (dec_page),
        .mask_o  (dec_mask)
    );

    assign beat_nx = st_q.beat + COL_W'(1);

    bcag_colgen #(.COL_W(COL_W)) u_colgen (
        .base_i (st_q.base),
        .beat_i (beat_nx),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .col_o  (col_nx)
    );

    assign at_end = !st_q.page && (st_q.beat == st_q.mask);

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (!st_q.active) begin
            if (start_i) begin
                if (dec_legal) begin
                    st_d.active = 1'b1;
                    st_d.base   = col_i;
                    st_d.beat   = '0;
                    st_d.mask   = dec_mask;
                    st_d.ilv    = burst_ilv_i;
                    st_d.page   = dec_page;
                    st_d.col    = col_i;
                    st_d.last   = !dec_page && (dec_mask == '0);
                end else begin
                    st_d.err = 1'b1;
                end
            end
        end else if (term_i || at_end) begin
            st_d.active = 1'b0;
            st_d.last   = 1'b0;
        end else begin
            st_d.beat = beat_nx;
            st_d.col  = col_nx;
            st_d.last = !st_q.page && (beat_nx == st_q.mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o   = st_q.col;
    assign valid_o = st_q.active;
    assign last_o  = st_q.last;
    assign busy_o  = st_q.active;
    assign err_o   = st_q.err;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] col_i,
    input logic [2:0]       bl_code_i,
    input logic             burst_ilv_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             busy_o,
    input logic             err_o
);

    logic [COL_W-1:0] cap_col;
    logic [COL_W-1:0] cap_mask;
    logic             cap_page;
    logic [COL_W:0]   beats;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_col  <= '0;
            cap_mask <= '0;
            cap_page <= 1'b0;
            beats    <= '0;
        end else if (start_i && !busy_o) begin
            cap_col  <= col_i;
            cap_page <= (bl_code_i == 3'b111);
            case (bl_code_i)
                3'b001:  cap_mask <= COL_W'(1);
                3'b010:  cap_mask <= COL_W'(3);
                3'b011:  cap_mask <= COL_W'(7);
                3'b111:  cap_mask <= '1;
                default: cap_mask <= '0;
            endcase
            beats <= '0;
        end else if (valid_o) begin
            beats <= beats + 1'b1;
        end
    end

    p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !cap_page) |-> (beats <= {1'b0, cap_mask}));

    p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !cap_page) |-> (((col_o ^ cap_col) & ~cap_mask) == '0));

    p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    p_last_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o);

    p_page_nolast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cap_page) |-> !last_o);

    p_term_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && term_i) |=> !valid_o);

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == valid_o);

    p_err_nobeat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o);

    p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;

    localparam int COL_W = 9;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic [2:0]       bl_code_i = '0;
    logic             burst_ilv_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, busy_o, err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
        .bl_code_i(bl_code_i), .burst_ilv_i(burst_ilv_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o),
        .busy_o(busy_o), .err_o(err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int s, input int n, input int bl, input bit ilv);
        int m = bl - 1;
        int lo = ilv ? ((s ^ n) & m) : ((s + n) & m);
        return (s & ~m & (PAGE - 1)) | lo;
    endfunction

    function automatic int code_len(input logic [2:0] c);
        case (c)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            default: return PAGE;
        endcase
    endfunction

    // drive start at a negedge; returns at the negedge where beat 0 shows
    task automatic launch(input int col, input logic [2:0] code, input bit ilv);
        @(negedge clk);
        start_i = 1'b1; col_i = COL_W'(col); bl_code_i = code; burst_ilv_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // R2 R3 R4 R5 R6: full fixed-length burst
    task automatic t_fixed(input int col, input logic [2:0] code, input bit ilv);
        int bl = code_len(code);
        launch(col, code, ilv);
        for (int n = 0; n < bl; n++) begin
            check("R2 valid", valid_o, 1);
            check(ilv ? "R5 column" : "R4 column", col_o, exp_col(col, n, bl, ilv));
            check("R3 block bits", col_o & ~(bl - 1) & (PAGE - 1), col & ~(bl - 1) & (PAGE - 1));
            check("R6 last", last_o, (n == bl - 1) ? 1 : 0);
            check("R9 busy", busy_o, 1);
            @(negedge clk);
        end
        check("R6 valid after last", valid_o, 0);
        check("R9 busy after end", busy_o, 0);
    endtask

    // R7 R8: page burst past a full lap, then terminate
    task automatic t_page();
        int col = 500;
        int total = PAGE + 20;
        launch(col, 3'b111, 1'b0);
        for (int n = 0; n < total; n++) begin
            check("R7 valid", valid_o, 1);
            check("R7 column", col_o, (col + n) % PAGE);
            check("R7 no last", last_o, 0);
            if (n == total - 1) term_i = 1'b1;
            @(negedge clk);
        end
        term_i = 1'b0;
        check("R8 valid after term", valid_o, 0);
    endtask

    // R8: early terminate of a fixed burst, and idle terminate
    task automatic t_term();
        launch(13, 3'b011, 1'b0);
        for (int n = 0; n < 3; n++) begin
            check("R8 column", col_o, exp_col(13, n, 8, 1'b0));
            if (n == 2) term_i = 1'b1;
            @(negedge clk);
        end
        term_i = 1'b0;
        check("R8 stopped", valid_o, 0);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        check("R8 idle term valid", valid_o, 0);
        check("R8 idle term err", err_o, 0);
        t_fixed(3, 3'b010, 1'b0);
    endtask

    // R9: start during a burst is ignored
    task automatic t_busy_start();
        launch(22, 3'b011, 1'b1);
        for (int n = 0; n < 8; n++) begin
            check("R9 column kept", col_o, exp_col(22, n, 8, 1'b1));
            check("R9 busy", busy_o, 1);
            if (n == 2) begin
                start_i = 1'b1; col_i = 9'd300; bl_code_i = 3'b001; burst_ilv_i = 1'b0;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        check("R9 no restart", valid_o, 0);
        check("R9 busy low", busy_o, 0);
    endtask

    // R10: rejected codes
    task automatic t_reject(input logic [2:0] code, input bit ilv);
        launch(40, code, ilv);
        check("R10 err pulse", err_o, 1);
        check("R10 no beat", valid_o, 0);
        @(negedge clk);
        check("R10 err cleared", err_o, 0);
        check("R10 still idle", valid_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", valid_o, 0);
        check("R1 last", last_o, 0);
        check("R1 busy", busy_o, 0);
        check("R1 err", err_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_fixed(77, 3'b000, 1'b0);
        t_fixed(9, 3'b001, 1'b0);
        t_fixed(9, 3'b001, 1'b1);
        t_fixed(255, 3'b010, 1'b0);
        t_fixed(255, 3'b010, 1'b1);
        t_fixed(6, 3'b011, 1'b0);
        t_fixed(6, 3'b011, 1'b1);
        t_fixed(509, 3'b011, 1'b0);
        t_fixed(5, 3'b011, 1'b1);
        t_page();
        t_term();
        t_busy_start();
        t_reject(3'b100, 1'b0);
        t_reject(3'b101, 1'b1);
        t_reject(3'b110, 1'b0);
        t_reject(3'b111, 1'b1);
        t_fixed(1, 3'b010, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule